// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block compares the phase of a shared reference signal against two comparison signals, using two separate detectors. The first detector is an exclusive-OR comparator. It takes the reference and one comparison input, and its output is high whenever the two sampled levels differ. The second detector is an edge-controlled set/reset comparator. A falling edge of the reference drives its output high, and a falling edge of its own comparison input drives it low. Each output is a one-bit error waveform that is meant to steer the up/down control of an external loop counter.

All three inputs are asynchronous. Each one passes through a two-flop synchronizer clocked by a fast system clock, and edges are found by comparing successive synchronized samples. At zero phase error each output is a square wave with a 50% duty cycle. The exclusive-OR detector reaches zero error when its inputs are a quarter cycle apart, which gives a gain of 4 per cycle of error. The edge detector reaches zero error at half a cycle apart, which gives a gain of 2 per cycle of error. At the ends of the linear range an output stays at one level. An optional monitor, selected by a parameter, raises a sticky flag per detector once that detector's output has held one value for a full observation window.

Top module: `dual_phase_det`

## Requirements
- R1: The XOR output is 0 when the synchronized reference and XOR-comparison levels are equal and 1 when they differ.
- R2: A falling edge of the reference, without a same-sample falling edge of the edge-comparison input, sets the edge output to 1, whatever the comparison level is.
- R3: A falling edge of the edge-comparison input, without a same-sample reference falling edge, clears the edge output to 0, whatever the reference level is.
- R4: Rising edges on either edge-detector input leave the edge output unchanged.
- R5: When falling edges on both edge-detector inputs land in the same sample, the edge output keeps its previous value.
- R6: A change on an input shows at a detector output at the third rising clock edge after it is set up, and not at the second.
- R7: While reset is asserted, and right after it is released, both detector outputs and both held flags are 0.
- R8: With a 16-cycle period, the XOR output has a 50% duty cycle when its inputs are a quarter period apart. The edge output has a 50% duty cycle when its inputs are half a period apart, and a 1/16 duty cycle when the comparison lags by one cycle.
- R9: When the XOR inputs are in phase, the output stays 0 for the whole period. When they are in antiphase, it stays 1 for the whole period.
- R10: A held flag goes to 1 once its detector output has been constant for WINDOW consecutive cycles (default 64), and then stays at 1 until reset.
- R11: A held flag stays 0 while its detector output changes more often than once per WINDOW cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| ref_in | input | 1 | Shared reference signal (asynchronous) |
| cmp_xor_in | input | 1 | Comparison signal for the XOR detector (asynchronous) |
| cmp_edge_in | input | 1 | Comparison signal for the edge detector (asynchronous) |
| xor_err_o | output | 1 | XOR detector error waveform |
| edge_err_o | output | 1 | Edge detector error waveform |
| xor_held_o | output | 1 | Sticky flag: XOR output constant for a full window |
| edge_held_o | output | 1 | Sticky flag: edge output constant for a full window |

## Verification
The bench targets the edge detector with falling edges on each input while the other input is held at both levels. If the set or clear were gated on the other input, the output would fail to move in one of those cases. It drives coincident falling edges starting from both output states, which catches a design that lets set or clear win instead of holding. It also drives rising edges alone, which catches a design that reacts to the wrong edge. Duty-cycle counts at quarter, half, one-cycle and zero offsets would expose a swapped detector, a wrong zero-error point, or an extra or missing synchronizer stage. The held flags are checked during toggling, after a long hold, and after toggling resumes, so a monitor that fires early, never fires, or forgets its state would be caught.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Raw asynchronous input lines, grouped for one synchronizer bank.
  typedef struct packed {
    logic edge_cmp;
    logic xor_cmp;
    logic refc;
  } pd_lines_t;

  localparam int unsigned PD_LINE_CNT = $bits(pd_lines_t);

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pd_fall_det.sv
module pd_fall_det #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  assign prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign fall_o = prev_q & ~level_i;

endmodule

// File: rtl/pd_xor_det.sv
module pd_xor_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic cmp_i,
  output logic err_o
);

  logic err_q;
  logic err_d;

  always_comb begin
    err_d = ref_i ^ cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  // R1: output is the difference of the levels seen one cycle earlier
  p_xor_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_o == ($past(ref_i) != $past(cmp_i))));

endmodule

// File: rtl/pd_ec_det.sv
module pd_ec_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_fall_i,
  input  logic cmp_fall_i,
  output logic err_o
);

  logic err_q;
  logic err_d;
  logic set_en;
  logic clr_en;

  always_comb begin
    set_en = ref_fall_i & ~cmp_fall_i;
    clr_en = cmp_fall_i & ~ref_fall_i;
    err_d  = err_q;
    if (set_en)      err_d = 1'b1;
    else if (clr_en) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  p_set_on_ref_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall_i && !cmp_fall_i) |=> err_o);

  p_clr_on_cmp_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fall_i && !ref_fall_i) |=> !err_o);

  // R4 (no fall at all) and R5 (both fall together): output holds
  p_hold_no_single_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall_i == cmp_fall_i) |=> $stable(err_o));

endmodule

// File: rtl/pd_hold_mon.sv
module pd_hold_mon #(
  parameter int unsigned WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic held_o
);

  localparam int unsigned CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WINDOW - 1);

  logic             last_q, last_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             held_q, held_d;
  logic             changed;

  always_comb begin
    changed = sig_i ^ last_q;
    last_d  = sig_i;
    if (changed)              cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
    held_d = held_q | (cnt_q == CNT_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      last_q <= last_d;
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign held_o = held_q;

  p_held_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held_o |=> held_o);

  // R11: flag cannot rise on a cycle whose input just changed
  p_no_rise_on_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_o && changed && cnt_q != CNT_TOP) |=> !held_o);

endmodule

// File: rtl/dual_phase_det.sv
module dual_phase_det #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          MON_EN      = 1'b1,
  parameter int unsigned WINDOW      = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic cmp_xor_in,
  input  logic cmp_edge_in,
  output logic xor_err_o,
  output logic edge_err_o,
  output logic xor_held_o,
  output logic edge_held_o
);

  import pd_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_int_n = rst_pipe_q[1];

  pd_lines_t lines_raw;
  pd_lines_t lines_syn;

  assign lines_raw = '{edge_cmp: cmp_edge_in, xor_cmp: cmp_xor_in, refc: ref_in};

  pd_sync #(
    .WIDTH  (PD_LINE_CNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (lines_raw),
    .sync_o  (lines_syn)
  );

  logic [1:0] falls;

  pd_fall_det #(.WIDTH(2)) u_fall (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i ({lines_syn.edge_cmp, lines_syn.refc}),
    .fall_o  (falls)
  );

  pd_xor_det u_xor (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ref_i (lines_syn.refc),
    .cmp_i (lines_syn.xor_cmp),
    .err_o (xor_err_o)
  );

  pd_ec_det u_ec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ref_fall_i (falls[0]),
    .cmp_fall_i (falls[1]),
    .err_o      (edge_err_o)
  );

  generate
    if (MON_EN) begin : g_mon
      pd_hold_mon #(.WINDOW(WINDOW)) u_mon_xor (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .sig_i  (xor_err_o),
        .held_o (xor_held_o)
      );
      pd_hold_mon #(.WINDOW(WINDOW)) u_mon_ec (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .sig_i  (edge_err_o),
        .held_o (edge_held_o)
      );
    end else begin : g_no_mon
      assign xor_held_o  = 1'b0;
      assign edge_held_o = 1'b0;
    end
  endgenerate

  p_reset_outputs_low_r7: assert property (@(posedge clk)
    !rst_int_n |-> (!xor_err_o && !edge_err_o && !xor_held_o && !edge_held_o));

endmodule

// File: tb/tb_dual_phase_det.sv
module tb_dual_phase_det;

  logic clk;
  logic rst_n;
  logic ref_in, cmp_xor_in, cmp_edge_in;
  logic xor_err_o, edge_err_o, xor_held_o, edge_held_o;

  int n_checks;
  int n_fail;
  bit done;

  dual_phase_det dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_in      (ref_in),
    .cmp_xor_in  (cmp_xor_in),
    .cmp_edge_in (cmp_edge_in),
    .xor_err_o   (xor_err_o),
    .edge_err_o  (edge_err_o),
    .xor_held_o  (xor_held_o),
    .edge_held_o (edge_held_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step(3);
    chk("R7 xor low in reset", xor_err_o, 0);
    chk("R7 edge low in reset", edge_err_o, 0);
    rst_n = 1'b1;
    step(3);
    chk("R7 flags low after reset", {xor_held_o, edge_held_o}, 0);
    chk("R7 outputs low after reset", {xor_err_o, edge_err_o}, 0);
  endtask

  task automatic t_monitor();
    // R11: toggle with 16-cycle period, both outputs change every 8 cycles
    for (int i = 0; i < 200; i++) begin
      ref_in      = ((i % 16) < 8);
      cmp_xor_in  = 1'b0;
      cmp_edge_in = (((i + 8) % 16) < 8);
      step(1);
    end
    chk("R11 xor flag clear while toggling", xor_held_o, 0);
    chk("R11 edge flag clear while toggling", edge_held_o, 0);
    step(150);
    chk("R10 xor flag set after hold", xor_held_o, 1);
    chk("R10 edge flag set after hold", edge_held_o, 1);
    for (int i = 0; i < 64; i++) begin
      ref_in      = ((i % 16) < 8);
      cmp_edge_in = (((i + 8) % 16) < 8);
      step(1);
    end
    chk("R10 xor flag sticky", xor_held_o, 1);
    chk("R10 edge flag sticky", edge_held_o, 1);
  endtask

  task automatic t_xor_table();
    for (int v = 0; v < 4; v++) begin
      ref_in     = v[0];
      cmp_xor_in = v[1];
      step(4);
      chk($sformatf("R1 xor table ref=%0d cmp=%0d", v[0], v[1]), xor_err_o, v[0] ^ v[1]);
    end
  endtask

  task automatic t_latency();
    ref_in = 1'b0; cmp_xor_in = 1'b0;
    step(4);
    ref_in = 1'b1;
    step(2);
    chk("R6 no change after two edges", xor_err_o, 0);
    step(1);
    chk("R6 change after three edges", xor_err_o, 1);
  endtask

  task automatic t_edge_set_clear();
    ref_in = 1'b1; cmp_edge_in = 1'b1;
    step(4);
    cmp_edge_in = 1'b0; step(3);
    chk("R3 clear with ref high", edge_err_o, 0);
    ref_in = 1'b0; step(3);
    chk("R2 set with cmp low", edge_err_o, 1);
    ref_in = 1'b1; step(3);
    chk("R4 ref rise ignored", edge_err_o, 1);
    cmp_edge_in = 1'b1; step(3);
    chk("R4 cmp rise ignored", edge_err_o, 1);
    cmp_edge_in = 1'b0; step(3);
    chk("R3 clear again", edge_err_o, 0);
    cmp_edge_in = 1'b1; step(3);
    chk("R4 cmp rise keeps low", edge_err_o, 0);
    ref_in = 1'b0; step(3);
    chk("R2 set with cmp high", edge_err_o, 1);
    cmp_edge_in = 1'b0; step(3);
    chk("R3 clear with ref low", edge_err_o, 0);
    ref_in = 1'b1; step(3);
    chk("R4 ref rise keeps low", edge_err_o, 0);
  endtask

  task automatic t_both_fall();
    ref_in = 1'b1; cmp_edge_in = 1'b1; step(4);
    ref_in = 1'b0; cmp_edge_in = 1'b0; step(4);
    chk("R5 coincident falls hold low", edge_err_o, 0);
    ref_in = 1'b1; step(3);
    ref_in = 1'b0; step(3);
    chk("R2 set before coincident test", edge_err_o, 1);
    ref_in = 1'b1; cmp_edge_in = 1'b1; step(4);
    ref_in = 1'b0; cmp_edge_in = 1'b0; step(4);
    chk("R5 coincident falls hold high", edge_err_o, 1);
  endtask

  task automatic t_duty(input int off_x, input int off_e,
                        input int exp_x, input int exp_e, input string tag);
    int hx, he;
    hx = 0; he = 0;
    for (int i = 0; i < 96; i++) begin
      if (i >= 32) begin
        hx += int'(xor_err_o);
        he += int'(edge_err_o);
      end
      ref_in      = ((i % 16) < 8);
      cmp_xor_in  = (((i + 16 - off_x) % 16) < 8);
      cmp_edge_in = (((i + 16 - off_e) % 16) < 8);
      step(1);
    end
    chk({tag, " xor high count"}, hx, exp_x);
    chk({tag, " edge high count"}, he, exp_e);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b1; ref_in = 1'b0; cmp_xor_in = 1'b0; cmp_edge_in = 1'b0;
    do_reset();
    t_monitor();
    do_reset();
    t_xor_table();
    t_latency();
    t_edge_set_clear();
    t_both_fall();
    t_duty(4, 8, 32, 32, "R8 zero-error");
    t_duty(0, 1, 0, 4, "R9 in-phase xor, R8 one-cycle lag edge");
    t_duty(8, 8, 64, 32, "R9 antiphase xor");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule